// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block is the counting core of a processor performance monitor. It holds four up-counting 32-bit counters. Each counter watches one line of a 128-bit event vector, and that line is chosen by a field in the counter's own control word. Every counter can be stopped in several ways: on its own, by the current privilege mode, by the state of a per-process mark bit, or together with all the others through a global freeze-all bit.

When a counter's most significant bit is set and that counter has its condition enabled, the block can raise a level interrupt request. It can also freeze every counter by setting the freeze-all bit itself. To be interrupted after N events, software loads a counter with 0x80000000 minus N. Software reaches every register through a single-cycle write port and a combinational read port, both addressed by a 4-bit address.

Top module: `pem_top`

## Requirements
- R1: A counter rises by exactly one on each clock edge at which its selected event line is high and it is not frozen. Otherwise it holds its value.
- R2: Control word A of each counter has five freeze bits. Bit 31 freezes the counter always. Bit 30 freezes it while `priv_sup` is 1. Bit 29 freezes it while `priv_sup` is 0. Bit 28 freezes it while `mark` is 1. Bit 27 freezes it while `mark` is 0.
- R3: Bits 22:16 of control word A select which line of `events` drives the counter. An index with no event line behind it counts nothing.
- R4: While bit 31 of the global register (freeze-all) is 1, no counter advances, whatever the local settings.
- R5: A counter's condition is true when bit 26 (condition enable) of its control word A is 1 and bit 31 of its count is 1.
- R6: `irq` is high exactly while bit 30 of the global register (interrupt enable) is 1 and at least one counter's condition is true. It stays high until software clears the count MSB, the condition enable or the interrupt enable.
- R7: While bit 29 of the global register (freeze on condition) is 1 and any condition is true, the freeze-all bit is set on the next clock edge. A software write to the global register in that cycle takes priority.
- R8: After a counter is loaded with 0x80000000 minus N, its condition becomes true after exactly N counted events.
- R9: A software write to a counter takes priority over an increment in the same cycle.
- R10: After reset, all counters read 0, every control word A reads 0xF8000000, every control word B reads 0, the global register reads 0 and `irq` is 0.
- R11: The address map is as follows. Address 0x0 is the global register. Addresses 0x4 to 0x7 are counters 0 to 3. Addresses 0x8 to 0xB are control words A 0 to 3. Addresses 0xC to 0xF are control words B 0 to 3. Addresses 0x1 to 0x3 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| events | input | 128 | Event lines, one per index |
| priv_sup | input | 1 | 1 in supervisor mode, 0 in user mode |
| mark | input | 1 | Process mark bit |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded assertions check on every cycle that a counter moves by at most one step unless it is written. They also check that a frozen counter (locally or globally) keeps its value, that a counter write lands on the next edge, that freeze-on-condition sets the freeze-all bit one edge later, and that `irq` is never high without a true condition. Some behaviours only the directed scenarios can show. These are the selection of the right event line, each freeze bit against the matching privilege and mark value, the exact event count from a preload to the interrupt, the one extra increment before the automatic freeze takes hold, the reset values and the unmapped addresses.

// File: rtl/pem_pkg.sv
// Shared constants for the event counter performance monitor.
// Assumes 32-bit registers and a 4-bit address map with at most four counters.
package pem_pkg;
    localparam int unsigned REG_W = 32;

    // Control word A field positions
    localparam int unsigned LA_FRZ     = 31;
    localparam int unsigned LA_FSUP    = 30;
    localparam int unsigned LA_FUSR    = 29;
    localparam int unsigned LA_FMK1    = 28;
    localparam int unsigned LA_FMK0    = 27;
    localparam int unsigned LA_CE      = 26;
    localparam int unsigned LA_SEL_LSB = 16;
    localparam int unsigned SEL_W_DEF  = 7;

    // Global register field positions
    localparam int unsigned GC_FAC   = 31;
    localparam int unsigned GC_IE    = 30;
    localparam int unsigned GC_FCECE = 29;

    // Address map
    localparam logic [3:0] ADR_GLB = 4'h0;
    localparam logic [1:0] PG_GLB  = 2'b00;
    localparam logic [1:0] PG_CNT  = 2'b01;
    localparam logic [1:0] PG_LA   = 2'b10;
    localparam logic [1:0] PG_LB   = 2'b11;

    // Reset value of control word A: all five freeze bits set
    localparam logic [REG_W-1:0] LA_RST =
        (REG_W'(1) << LA_FRZ)  | (REG_W'(1) << LA_FSUP) | (REG_W'(1) << LA_FUSR) |
        (REG_W'(1) << LA_FMK1) | (REG_W'(1) << LA_FMK0);
endpackage

// File: rtl/pem_slice.sv
// One counter of the performance monitor, with its two control words.
// Works out the local freeze, selects the event line, counts, and reports
// the condition (enable AND count MSB). Assumes the top decodes writes.
module pem_slice
    import pem_pkg::*;
#(
    parameter int unsigned NUM_EVENTS = 128,
    parameter int unsigned SEL_W      = SEL_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] events,
    input  logic                  priv_sup,
    input  logic                  mark,
    input  logic                  frz_all,
    input  logic                  cnt_we,
    input  logic                  la_we,
    input  logic                  lb_we,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      cnt_q,
    output logic [REG_W-1:0]      la_q,
    output logic [REG_W-1:0]      lb_q,
    output logic                  cond
);
    localparam int unsigned SEL_SPAN = 1 << SEL_W;

    logic [SEL_SPAN-1:0] ev_pad;
    logic [SEL_W-1:0]    sel;
    logic                frz_local;
    logic                inc;

    // Pad or trim the event vector to the select range; missing lines are 0
    generate
        if (NUM_EVENTS >= SEL_SPAN) begin : g_trim
            assign ev_pad = events[SEL_SPAN-1:0];
        end else begin : g_pad
            assign ev_pad = {{(SEL_SPAN-NUM_EVENTS){1'b0}}, events};
        end
    endgenerate

    // Local freeze from the control word, privilege mode and mark bit
    always_comb begin
        frz_local = la_q[LA_FRZ]
                  | ( priv_sup & la_q[LA_FSUP])
                  | (~priv_sup & la_q[LA_FUSR])
                  | ( mark     & la_q[LA_FMK1])
                  | (~mark     & la_q[LA_FMK0]);
    end

    assign sel  = la_q[LA_SEL_LSB +: SEL_W];
    assign inc  = ev_pad[sel] & ~frz_local & ~frz_all;
    assign cond = la_q[LA_CE] & cnt_q[REG_W-1];

    // Counter: a software write wins over the increment
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_we) cnt_q <= wdata;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    // Control words A and B
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la_q <= LA_RST;
            lb_q <= '0;
        end else begin
            if (la_we) la_q <= wdata;
            if (lb_we) lb_q <= wdata;
        end
    end

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
    p_local_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_local && !cnt_we) |=> $stable(cnt_q));
    p_global_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_all && !cnt_we) |=> $stable(cnt_q));
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt_q == $past(wdata));
endmodule

// File: rtl/pem_glob.sv
// Global control register and interrupt request of the performance monitor.
// Sets freeze-all on its own one edge after a condition while freeze on
// condition is enabled; a software write takes priority.
module pem_glob
    import pem_pkg::*;
#(
    parameter int unsigned NUM_CTR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_CTR-1:0] cond_vec,
    output logic [REG_W-1:0]   glb_q,
    output logic               frz_all,
    output logic               irq
);
    logic any_cond;

    assign any_cond = |cond_vec;
    assign frz_all  = glb_q[GC_FAC];
    assign irq      = glb_q[GC_IE] & any_cond;

    // Global register with automatic freeze-all on condition
    always_ff @(posedge clk) begin
        if (!rst_n)
            glb_q <= '0;
        else if (we)
            glb_q <= wdata;
        else if (glb_q[GC_FCECE] && any_cond)
            glb_q[GC_FAC] <= 1'b1;
    end

    p_auto_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_q[GC_FCECE] && any_cond && !we) |=> frz_all);
endmodule

// File: rtl/pem_top.sv
// Event counter performance monitor top: register decode, read mux,
// NUM_CTR counter slices and the global control. Assumes NUM_CTR <= 4
// (the address map has room for four counters).
module pem_top
    import pem_pkg::*;
#(
    parameter int unsigned NUM_CTR    = 4,
    parameter int unsigned NUM_EVENTS = 128,
    parameter int unsigned SEL_W      = SEL_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [3:0]            addr,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rdata,
    input  logic [NUM_EVENTS-1:0] events,
    input  logic                  priv_sup,
    input  logic                  mark,
    output logic                  irq
);
    logic [REG_W-1:0]   cnt_arr [NUM_CTR];
    logic [REG_W-1:0]   la_arr  [NUM_CTR];
    logic [REG_W-1:0]   lb_arr  [NUM_CTR];
    logic [NUM_CTR-1:0] cond_vec;
    logic [REG_W-1:0]   glb_q;
    logic               frz_all;
    logic               glb_we;
    logic [1:0]         page;
    logic [1:0]         idx;

    assign page   = addr[3:2];
    assign idx    = addr[1:0];
    assign glb_we = wr_en && (addr == ADR_GLB);

    generate
        for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
            logic cnt_we, la_we, lb_we;
            assign cnt_we = wr_en && (page == PG_CNT) && (idx == 2'(g));
            assign la_we  = wr_en && (page == PG_LA)  && (idx == 2'(g));
            assign lb_we  = wr_en && (page == PG_LB)  && (idx == 2'(g));

            pem_slice #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)) u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .events   (events),
                .priv_sup (priv_sup),
                .mark     (mark),
                .frz_all  (frz_all),
                .cnt_we   (cnt_we),
                .la_we    (la_we),
                .lb_we    (lb_we),
                .wdata    (wdata),
                .cnt_q    (cnt_arr[g]),
                .la_q     (la_arr[g]),
                .lb_q     (lb_arr[g]),
                .cond     (cond_vec[g])
            );
        end
    endgenerate

    pem_glob #(.NUM_CTR(NUM_CTR)) u_glob (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (glb_we),
        .wdata    (wdata),
        .cond_vec (cond_vec),
        .glb_q    (glb_q),
        .frz_all  (frz_all),
        .irq      (irq)
    );

    // Read mux; unmapped addresses and absent counters read 0
    always_comb begin
        rdata = '0;
        if (page == PG_GLB) begin
            if (idx == 2'd0) rdata = glb_q;
        end else if (int'(idx) < NUM_CTR) begin
            case (page)
                PG_CNT:  rdata = cnt_arr[idx];
                PG_LA:   rdata = la_arr[idx];
                default: rdata = lb_arr[idx];
            endcase
        end
    end

    p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|cond_vec));
    p_reset_irq_r10: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

// File: tb/pem_top_tb_top.sv
// Directed bench for pem_top: one task per scenario, each checking its results.
module pem_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [3:0]   addr = 4'h0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [127:0] events = '0;
    logic         priv_sup = 1'b0;
    logic         mark = 1'b0;
    logic         irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pem_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .events(events), .priv_sup(priv_sup), .mark(mark), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse(input int line, input int n);
        events[line] = 1'b1;
        repeat (n) @(negedge clk);
        events[line] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'h0, d); chk("R10 global", d, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(4'(4 + i), d);  chk("R10 counter", d, 32'h0);
            rd(4'(8 + i), d);  chk("R10 ctlA", d, 32'hF800_0000);
            rd(4'(12 + i), d); chk("R10 ctlB", d, 32'h0);
        end
        chk("R10 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        wr(4'h8, 32'h0005_0000); wr(4'h9, 32'h007F_0000);
        wr(4'h4, 0); wr(4'h5, 0);
        pulse(5, 10); pulse(127, 3); pulse(6, 4);
        rd(4'h4, d); chk("R1/R3 ctr0 sel5", d, 32'd10);
        rd(4'h5, d); chk("R1/R3 ctr1 sel127", d, 32'd3);
    endtask

    task automatic frz_case(input string req, input logic [31:0] bits,
                            input logic p, input logic m, input logic [31:0] exp);
        logic [31:0] d;
        wr(4'h8, 32'h0005_0000 | bits); wr(4'h4, 0);
        priv_sup = p; mark = m;
        pulse(5, 3);
        rd(4'h4, d); chk(req, d, exp);
        priv_sup = 1'b0; mark = 1'b0;
    endtask

    task automatic t_freeze();
        frz_case("R2 sup frozen",   32'h4000_0000, 1, 0, 0);
        frz_case("R2 sup in user",  32'h4000_0000, 0, 0, 3);
        frz_case("R2 usr frozen",   32'h2000_0000, 0, 0, 0);
        frz_case("R2 usr in sup",   32'h2000_0000, 1, 0, 3);
        frz_case("R2 mark1 frozen", 32'h1000_0000, 0, 1, 0);
        frz_case("R2 mark0 frozen", 32'h0800_0000, 0, 0, 0);
        frz_case("R2 mark0 open",   32'h0800_0000, 0, 1, 3);
        frz_case("R2 unconditional",32'h8000_0000, 1, 1, 0);
    endtask

    task automatic t_freeze_all();
        logic [31:0] d;
        wr(4'h8, 32'h0005_0000); wr(4'h9, 32'h0005_0000);
        wr(4'h4, 32'd7); wr(4'h5, 32'd9);
        wr(4'h0, 32'h8000_0000);
        pulse(5, 5);
        rd(4'h4, d); chk("R4 ctr0 held", d, 32'd7);
        rd(4'h5, d); chk("R4 ctr1 held", d, 32'd9);
        wr(4'h0, 0);
        pulse(5, 2);
        rd(4'h4, d); chk("R4 ctr0 resumes", d, 32'd9);
    endtask

    task automatic t_write_prio();
        logic [31:0] d;
        wr(4'h8, 32'h0005_0000); wr(4'h4, 0);
        events[5] = 1'b1;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; addr = 4'h4; wdata = 32'h100;
        @(negedge clk);
        wr_en = 1'b0; events[5] = 1'b0;
        rd(4'h4, d); chk("R9 write over increment", d, 32'h100);
    endtask

    task automatic t_cond_irq();
        logic [31:0] d;
        wr(4'hA, 32'h040A_0000); wr(4'h6, 32'h8000_0000 - 7);
        wr(4'h0, 32'h4000_0000);
        pulse(10, 6);
        #1 chk("R8 no irq after N-1", {31'b0, irq}, 0);
        rd(4'h6, d); chk("R8 count N-1", d, 32'h7FFF_FFFF);
        pulse(10, 1);
        #1 chk("R8 irq after N", {31'b0, irq}, 1);
        repeat (3) @(negedge clk);
        #1 chk("R6 irq level held", {31'b0, irq}, 1);
        wr(4'h0, 0);
        #1 chk("R6 irq gated by enable", {31'b0, irq}, 0);
        wr(4'h6, 0);
        wr(4'hB, 32'h000B_0000); wr(4'h7, 32'h8000_0000);
        wr(4'h0, 32'h4000_0000);
        #1 chk("R5 MSB without enable", {31'b0, irq}, 0);
        wr(4'hB, 32'h040B_0000);
        #1 chk("R5 MSB with enable", {31'b0, irq}, 1);
        wr(4'h7, 0);
        #1 chk("R6 irq drops on MSB clear", {31'b0, irq}, 0);
        wr(4'h0, 0);
    endtask

    task automatic t_auto_freeze();
        logic [31:0] d;
        wr(4'h8, 32'h0405_0000); wr(4'h9, 32'h0005_0000);
        wr(4'h4, 32'h8000_0000 - 3); wr(4'h5, 0);
        wr(4'h0, 32'h6000_0000);
        pulse(5, 6);
        rd(4'h0, d); chk("R7 freeze-all set", d, 32'hE000_0000);
        rd(4'h4, d); chk("R7 ctr0 one step past MSB", d, 32'h8000_0001);
        rd(4'h5, d); chk("R7 ctr1 stopped", d, 32'd4);
        #1 chk("R7 irq raised", {31'b0, irq}, 1);
        wr(4'h0, 0); wr(4'h4, 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(4'h1, 32'hDEAD_BEEF);
        rd(4'h1, d); chk("R11 unmapped reads 0", d, 0);
        rd(4'h0, d); chk("R11 global untouched", d, 0);
        wr(4'hD, 32'h1234_5678);
        rd(4'hD, d); chk("R11 ctlB1 readback", d, 32'h1234_5678);
        rd(4'hC, d); chk("R11 ctlB0 untouched", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_freeze();
        t_freeze_all();
        t_write_prio();
        t_cond_irq();
        t_auto_freeze();
        t_map();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule